// File: doc/BRIEF.md
# Dithered 14-bit Pulse-Width DAC

This block turns a 14-bit value into a single pulse-width-modulated pin whose average, after an external low-pass filter, gives a tuning or control voltage. The modulator runs in frames of 128 ticks, and each tick lasts `PRESCALE` clocks. The upper seven value bits set a coarse high time at the start of every frame. The lower seven bits, N, choose how many frames out of every 128 get one extra tick. These stretched frames are spread evenly by comparing the bit-reversed frame index with N, so the average value has fourteen bits of resolution and the dither stays at a high frequency.

Software loads the value through two byte registers on a simple write bus. A write to the low byte only stages the byte. A write to the high byte carries the enable and the top value bits, and it commits the whole 14-bit value in one step. While the modulator is running, the committed value reaches the counter only at the next frame boundary, so no frame is cut short. When the enable is clear, the pin passes a general-purpose port latch bit through unchanged.

A three-state sequencer controls the modulator. `ST_PORT` is idle, with the counters held at zero. `ST_RUN` counts frames using the active value. `ST_ARMED` counts frames while a newly committed value waits for the frame boundary. The transitions are:
- PORT→RUN: a high-byte write with the enable set. The value loads at once and the frame starts at phase 0.
- RUN→ARMED: a high-byte write with the enable set.
- ARMED→RUN: the end of a frame, which loads the pending value.
- RUN or ARMED→PORT: a high-byte write with the enable clear.
- ARMED→ARMED: a further enabled high-byte write, which replaces the pending value.

Top module: `dith_pwm14`

## Requirements
- R1: After reset, the enable is 0, the pin equals `port_bit`, and both registers read back 0x00.
- R2: While the modulator runs, a frame lasts 128 ticks of `PRESCALE` (default 4) clocks. The pin is high for the first C ticks of the frame and low for the rest, where C is value bits 13..7.
- R3: Frames are numbered k = 0, 1, 2, … from the cycle the modulator starts. Frame k gets one extra high tick exactly when the bit-reversed 7-bit value of (k mod 128) is less than N, where N is value bits 6..0. Every 128 consecutive frames therefore contain exactly N stretched frames.
- R4: A write to the low-byte address (0xD2) stages value bits 7..0 only. It changes neither the running pulse nor the enable.
- R5: A write to the high-byte address (0xD3) commits value = {data[5:0], staged low byte} and sets the enable to data[7]. Data bit 6 is ignored.
- R6: If a high-byte write with the enable set arrives while the modulator is running, the current frame finishes with the old value and the new value applies from the next frame.
- R7: A high-byte write with the enable clear hands the pin to `port_bit` from the next cycle, and the frame counters stop.
- R8: Reading address 0xD3 returns {enable, 0, value bits 13..8}, so bit 6 always reads 0. Reading 0xD2 returns the staged low byte. Any other address reads 0x00.
- R9: Writes to addresses other than 0xD2 and 0xD3 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock (tick source before prescaling) |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 8 | Register read address |
| rd_data | output | 8 | Register read data (combinational) |
| port_bit | input | 1 | Port latch bit driven to the pin when the enable is clear |
| pin | output | 1 | Modulator or port output |

## Verification
The checker watches several properties on every cycle:
- the enable and the sequencer state always agree;
- a low-byte write never disturbs the committed or active value;
- the active value never changes in `ST_RUN` without a high-byte write;
- the counters stay at zero when the modulator is idle;
- the pin stays low during a frame with zero width and no stretch.

Other behaviour can only be shown by the bench's scenarios, because it depends on measuring whole frames:
- the high time of each frame;
- which frames are stretched across a full 128-frame cycle;
- the exact frame at which a committed value first appears.

// File: rtl/dith_pwm14_pkg.sv
package dith_pwm14_pkg;

    typedef enum logic [1:0] {
        ST_PORT  = 2'd0,
        ST_RUN   = 2'd1,
        ST_ARMED = 2'd2
    } pwm_state_t;

endpackage

// File: rtl/dith_pwm14_regs.sv
module dith_pwm14_regs #(
    parameter int          VW      = 14,
    parameter logic [7:0]  ADDR_LO = 8'hD2,
    parameter logic [7:0]  ADDR_HI = 8'hD3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [7:0]    wr_addr,
    input  logic [7:0]    wr_data,
    input  logic [7:0]    rd_addr,
    output logic [7:0]    rd_data,
    output logic          lo_wr,
    output logic          hi_wr,
    output logic          new_en,
    output logic [VW-1:0] new_val,
    output logic          en_q,
    output logic [VW-1:0] pend_val
);
    localparam int HIB = VW - 8;    // value bits carried by the high byte
    localparam int PAD = 7 - HIB;   // unused bits between enable and value

    logic [7:0] lo_stage;

    assign lo_wr   = wr_en && (wr_addr == ADDR_LO);
    assign hi_wr   = wr_en && (wr_addr == ADDR_HI);
    assign new_en  = wr_data[7];
    assign new_val = {wr_data[HIB-1:0], lo_stage};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lo_stage <= '0;
            en_q     <= 1'b0;
            pend_val <= '0;
        end else begin
            if (lo_wr) begin
                lo_stage <= wr_data;
            end
            if (hi_wr) begin
                en_q     <= new_en;
                pend_val <= new_val;
            end
        end
    end

    always_comb begin
        if (rd_addr == ADDR_HI) begin
            rd_data = {en_q, {PAD{1'b0}}, pend_val[VW-1:8]};
        end else if (rd_addr == ADDR_LO) begin
            rd_data = lo_stage;
        end else begin
            rd_data = 8'h00;
        end
    end
endmodule

// File: rtl/dith_pwm14_seq.sv
module dith_pwm14_seq
    import dith_pwm14_pkg::*;
#(
    parameter int CW       = 7,
    parameter int FW       = 7,
    parameter int PRESCALE = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hi_wr,
    input  logic             new_en,
    input  logic [CW+FW-1:0] new_val,
    input  logic [CW+FW-1:0] pend_val,
    output pwm_state_t       state,
    output logic [CW-1:0]    phase,
    output logic [FW-1:0]    frame_idx,
    output logic [CW+FW-1:0] act_val
);
    localparam int          PW        = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
    localparam logic [PW-1:0] PRE_LAST = PW'(PRESCALE - 1);
    localparam logic [CW-1:0] PH_LAST  = {CW{1'b1}};

    pwm_state_t    state_nx;
    logic [PW-1:0] presc;
    logic          tick;
    logic          frame_end;
    logic          start;

    assign tick      = (state != ST_PORT) && (presc == PRE_LAST);
    assign frame_end = tick && (phase == PH_LAST);
    assign start     = (state == ST_PORT) && hi_wr && new_en;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_PORT;
        end else begin
            state <= state_nx;
        end
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_PORT: begin
                if (hi_wr && new_en) begin
                    state_nx = ST_RUN;
                end
            end
            ST_RUN: begin
                if (hi_wr) begin
                    state_nx = new_en ? ST_ARMED : ST_PORT;
                end
            end
            ST_ARMED: begin
                if (hi_wr) begin
                    state_nx = new_en ? ST_ARMED : ST_PORT;
                end else if (frame_end) begin
                    state_nx = ST_RUN;
                end
            end
            default: state_nx = ST_PORT;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            presc     <= '0;
            phase     <= '0;
            frame_idx <= '0;
            act_val   <= '0;
        end else if (start) begin
            presc     <= '0;
            phase     <= '0;
            frame_idx <= '0;
            act_val   <= new_val;
        end else if (state == ST_PORT) begin
            presc     <= '0;
            phase     <= '0;
            frame_idx <= '0;
        end else begin
            presc <= tick ? '0 : presc + 1'b1;
            if (tick) begin
                phase <= phase + 1'b1;
            end
            if (frame_end) begin
                frame_idx <= frame_idx + 1'b1;
                if (state == ST_ARMED) begin
                    act_val <= pend_val;
                end
            end
        end
    end
endmodule

// File: rtl/dith_pwm14_dither.sv
module dith_pwm14_dither #(
    parameter int FW = 7
) (
    input  logic [FW-1:0] frame_idx,
    input  logic [FW-1:0] fine,
    output logic          stretch
);
    logic [FW-1:0] rev_idx;

    for (genvar i = 0; i < FW; i++) begin : g_rev
        assign rev_idx[i] = frame_idx[FW-1-i];
    end

    assign stretch = (rev_idx < fine);
endmodule

// File: rtl/dith_pwm14.sv
module dith_pwm14
    import dith_pwm14_pkg::*;
#(
    parameter int         CW       = 7,
    parameter int         FW       = 7,
    parameter int         PRESCALE = 4,
    parameter logic [7:0] ADDR_LO  = 8'hD2,
    parameter logic [7:0] ADDR_HI  = 8'hD3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [7:0] wr_addr,
    input  logic [7:0] wr_data,
    input  logic [7:0] rd_addr,
    output logic [7:0] rd_data,
    input  logic       port_bit,
    output logic       pin
);
    localparam int VW = CW + FW;

    logic          lo_wr;
    logic          hi_wr;
    logic          new_en;
    logic [VW-1:0] new_val;
    logic          en_q;
    logic [VW-1:0] pend_val;
    pwm_state_t    state;
    logic [CW-1:0] phase;
    logic [FW-1:0] frame_idx;
    logic [VW-1:0] act_val;
    logic          stretch;
    logic [CW:0]   width_eff;
    logic          pwm_raw;

    dith_pwm14_regs #(
        .VW(VW), .ADDR_LO(ADDR_LO), .ADDR_HI(ADDR_HI)
    ) u_regs (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data),
        .lo_wr(lo_wr), .hi_wr(hi_wr), .new_en(new_en), .new_val(new_val),
        .en_q(en_q), .pend_val(pend_val)
    );

    dith_pwm14_seq #(
        .CW(CW), .FW(FW), .PRESCALE(PRESCALE)
    ) u_seq (
        .clk(clk), .rst_n(rst_n),
        .hi_wr(hi_wr), .new_en(new_en), .new_val(new_val), .pend_val(pend_val),
        .state(state), .phase(phase), .frame_idx(frame_idx), .act_val(act_val)
    );

    dith_pwm14_dither #(
        .FW(FW)
    ) u_dither (
        .frame_idx(frame_idx),
        .fine(act_val[FW-1:0]),
        .stretch(stretch)
    );

    // Coarse width plus optional extra tick; one bit wider to hold a full frame.
    assign width_eff = {1'b0, act_val[VW-1:FW]} + {{CW{1'b0}}, stretch};
    assign pwm_raw   = (state != ST_PORT) && ({1'b0, phase} < width_eff);
    assign pin       = en_q ? pwm_raw : port_bit;
endmodule

// File: rtl/dith_pwm14_chk.sv
module dith_pwm14_chk
    import dith_pwm14_pkg::*;
#(
    parameter int CW = 7,
    parameter int FW = 7
) (
    input logic             clk,
    input logic             rst_n,
    input pwm_state_t       state,
    input logic             en_q,
    input logic             lo_wr,
    input logic             hi_wr,
    input logic [CW-1:0]    phase,
    input logic [CW+FW-1:0] act_val,
    input logic [CW+FW-1:0] pend_val,
    input logic             stretch,
    input logic             pin,
    input logic [7:0]       rd_data,
    input logic [7:0]       rd_addr
);
    // R7: enable and sequencer agree on every cycle
    assert_en_state_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (en_q == (state != ST_PORT)));

    // R4: a low-byte write alone leaves committed and active values untouched
    assert_lo_stage_only_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (lo_wr && !hi_wr && state == ST_RUN) |=> ($stable(pend_val) && $stable(act_val)));

    // R6: active value holds in RUN unless a high write occurs
    assert_run_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN && !hi_wr) |=> $stable(act_val));

    // R7: counters rest at zero while idle
    assert_idle_phase_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PORT) |=> (phase == '0));

    // R2: zero coarse width without stretch keeps the pin low
    assert_zero_width_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_PORT && act_val[CW+FW-1:FW] == '0 && !stretch) |-> !pin);

    // R8: high-byte bit 6 always reads zero
    assert_unused_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_addr == 8'hD3) |-> !rd_data[6]);
endmodule

bind dith_pwm14 dith_pwm14_chk #(.CW(CW), .FW(FW)) u_chk (
    .clk(clk), .rst_n(rst_n), .state(state), .en_q(en_q),
    .lo_wr(lo_wr), .hi_wr(hi_wr), .phase(phase), .act_val(act_val),
    .pend_val(pend_val), .stretch(stretch), .pin(pin),
    .rd_data(rd_data), .rd_addr(rd_addr)
);

// File: tb/dith_pwm14_bench.sv
`timescale 1ns/1ps
module dith_pwm14_bench;
    localparam int FRAME_CLK = 512;
    localparam int NVEC      = 6;
    // {lo byte, hi byte, expected high clocks in frame 0, in frame 1}
    localparam logic [35:0] VEC [NVEC] = '{
        {8'h00, 8'h80, 10'd0,   10'd0},
        {8'h00, 8'h85, 10'd40,  10'd40},
        {8'h01, 8'h85, 10'd44,  10'd40},
        {8'hFF, 8'hBF, 10'd512, 10'd512},
        {8'h41, 8'hA0, 10'd260, 10'd260},
        {8'hC0, 8'h81, 10'd16,  10'd12}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_addr = 8'h00;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] rd_addr = 8'h00;
    logic [7:0] rd_data;
    logic       port_bit = 1'b0;
    logic       pin;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    dith_pwm14 u_dith_pwm14 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .port_bit(port_bit), .pin(pin)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Called at a negedge; the write commits at the next posedge.
    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(posedge clk); #1;
        wr_en = 1'b0; wr_addr = 8'h00; wr_data = 8'h00;
        @(negedge clk);
    endtask

    // Write that starts a frame; leaves time just after the commit edge.
    task automatic wr_start(input logic [7:0] a, input logic [7:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(posedge clk); #1;
        wr_en = 1'b0; wr_addr = 8'h00; wr_data = 8'h00;
    endtask

    task automatic measure(output int hi);
        hi = 0;
        for (int i = 0; i < FRAME_CLK; i++) begin
            @(negedge clk);
            if (pin) hi++;
        end
    endtask

    task automatic rd(input logic [7:0] a, input logic [7:0] exp, input string req);
        rd_addr = a; #1;
        check(rd_data == exp, req, rd_data, exp);
    endtask

    initial begin
        int h0, h1, nstr;
        bit all_ok;
        repeat (3) @(negedge clk);
        // R1: reset state
        port_bit = 1'b1; #1;
        check(pin == 1'b1, "R1 pin follows port high", pin, 1);
        port_bit = 1'b0; #1;
        check(pin == 1'b0, "R1 pin follows port low", pin, 0);
        rd(8'hD3, 8'h00, "R1 high readback");
        rd(8'hD2, 8'h00, "R1 low readback");
        rst_n = 1'b1;
        @(negedge clk);

        // Vector table: R2 coarse width, R3 first frames, R5 commit
        for (int v = 0; v < NVEC; v++) begin
            wr(8'hD3, 8'h00);
            wr(8'hD2, VEC[v][35:28]);
            wr_start(8'hD3, VEC[v][27:20]);
            measure(h0);
            measure(h1);
            check(h0 == int'(VEC[v][19:10]), "R2/R3 frame0", h0, int'(VEC[v][19:10]));
            check(h1 == int'(VEC[v][9:0]),   "R2/R3 frame1", h1, int'(VEC[v][9:0]));
        end

        // R8: bit 6 reads 0, R5 enable from bit 7
        wr(8'hD3, 8'h7F);
        rd(8'hD3, 8'h3F, "R8 unused bit with enable clear");
        wr(8'hD3, 8'hFF);
        rd(8'hD3, 8'hBF, "R8 unused bit with enable set");
        wr(8'hD3, 8'h00);

        // R9: foreign address ignored
        wr(8'hD2, 8'h5A);
        wr(8'hD1, 8'hFF);
        rd(8'hD2, 8'h5A, "R9 low unchanged");
        rd(8'hD3, 8'h00, "R9 high unchanged");
        rd(8'hD1, 8'h00, "R8 other address reads 0");

        // R4: low write while running does not change the pulse
        wr(8'hD2, 8'h00);
        wr_start(8'hD3, 8'h85);
        h0 = 0;
        for (int i = 0; i < FRAME_CLK; i++) begin
            @(negedge clk);
            if (pin) h0++;
            if (i == 100) begin wr_en = 1'b1; wr_addr = 8'hD2; wr_data = 8'hFF; end
            if (i == 101) begin wr_en = 1'b0; wr_addr = 8'h00; wr_data = 8'h00; end
        end
        measure(h1);
        check(h0 == 40, "R4 frame during low write", h0, 40);
        check(h1 == 40, "R4 frame after low write", h1, 40);
        rd(8'hD2, 8'hFF, "R8 staged low readback");
        rd(8'hD3, 8'h85, "R4 enable kept");

        // R6: mid-frame high write applies from next frame
        @(negedge clk);
        wr(8'hD3, 8'h00);
        wr(8'hD2, 8'h00);
        wr_start(8'hD3, 8'h85);
        h0 = 0;
        for (int i = 0; i < FRAME_CLK; i++) begin
            @(negedge clk);
            if (pin) h0++;
            if (i == 100) begin wr_en = 1'b1; wr_addr = 8'hD3; wr_data = 8'h86; end
            if (i == 101) begin wr_en = 1'b0; wr_addr = 8'h00; wr_data = 8'h00; end
        end
        measure(h1);
        check(h0 == 40, "R6 current frame keeps old value", h0, 40);
        check(h1 == 48, "R6 next frame uses new value", h1, 48);

        // R7: disable hands pin to port bit
        @(negedge clk);
        wr(8'hD3, 8'h05);
        port_bit = 1'b1; #1;
        check(pin == 1'b1, "R7 port high after disable", pin, 1);
        port_bit = 1'b0; #1;
        check(pin == 1'b0, "R7 port low after disable", pin, 0);
        rd(8'hD3, 8'h05, "R7 enable readback clear");

        // R3: full 128-frame cycle, C=2 N=5
        wr(8'hD2, 8'h05);
        wr_start(8'hD3, 8'h81);
        nstr = 0;
        all_ok = 1'b1;
        for (int k = 0; k < 128; k++) begin
            logic [6:0] kk, rv;
            int exp_hi;
            kk = 7'(k);
            for (int b = 0; b < 7; b++) rv[b] = kk[6-b];
            exp_hi = 4 * (2 + ((rv < 7'd5) ? 1 : 0));
            measure(h0);
            if (h0 == 12) nstr++;
            if (h0 != exp_hi) begin
                if (all_ok) check(1'b0, "R3 frame pattern", h0, exp_hi);
                all_ok = 1'b0;
            end
        end
        if (all_ok) check(1'b1, "R3 frame pattern", 0, 0);
        check(nstr == 5, "R3 stretched frames per cycle", nstr, 5);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule